// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Logic

This block keeps the transmit-side status of a CAN controller that has several transmit mailboxes. For each mailbox it tracks whether a frame is waiting to go out. It records how the latest attempt on the bus ended: success, lost arbitration or a bus error. It also holds a software abort request until that request can take effect. All of this is presented as one packed 32-bit word for register reads.

Software drives the block in two ways. A per-mailbox request strobe queues a frame. A write strobe with a 32-bit data word lets software clear the completion flags (write one to clear) and raise abort requests (write one to set). The protocol engine reports the result of each attempt as a one-cycle pulse per mailbox. It also marks which mailbox it is currently sending, and an abort is held off while that mailbox is on the bus. A mailbox that loses arbitration or hits an error stays queued for retry unless an abort is waiting.

Top module: `canmb_status`

## Requirements
- R1: After a synchronous reset every mailbox is empty (`pending_o` = 0) and `status_o` is all zeros.
- R2: Mailbox k uses status byte k, bits 8k+7..8k. Within the byte, bit 0 is done, bit 1 is tx-ok, bit 2 is arb-lost, bit 3 is tx-error and bit 7 is abort. Bits 6..4 of every byte and all bits above the last mailbox read as 0.
- R3: A request strobe on an empty mailbox makes it pending in the next cycle and clears its done, tx-ok, arb-lost and tx-error bits. A request strobe on a pending mailbox is ignored.
- R4: An ok pulse on a pending mailbox empties it and sets done and tx-ok. The abort bit is cleared.
- R5: An arb-lost or error pulse on a pending mailbox with no abort set leaves it pending and clears tx-ok. It sets arb-lost or tx-error respectively, and these two stay set until done is cleared. When pulses coincide, ok takes priority over arb-lost, and arb-lost over error.
- R6: A write with data bit 8k+0 at 1 clears done, tx-ok, arb-lost and tx-error of mailbox k. A 0 in that bit leaves them unchanged.
- R7: A write with data bit 8k+7 at 1 sets the abort bit of a pending mailbox. On an empty mailbox it has no effect and the bit stays 0.
- R8: A pending mailbox with abort set empties when it is not marked active, or when it receives an arb-lost or error pulse. It then sets done and clears abort. While it is marked active and no pulse arrives, it stays pending.
- R9: When a mailbox empties in the same cycle as a write-1 clear of its done bit, done ends at 1 and the outcome bits are not cleared.
- R10: Outcome pulses on an empty mailbox change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req_i | input | 3 | Per-mailbox transmit request strobe |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Write data: bit 8k+0 clears done (write 1), bit 8k+7 sets abort (write 1) |
| active_i | input | 3 | Engine is currently sending this mailbox |
| ev_ok_i | input | 3 | Per-mailbox successful attempt pulse |
| ev_arb_i | input | 3 | Per-mailbox arbitration-lost pulse |
| ev_err_i | input | 3 | Per-mailbox bus-error pulse |
| status_o | output | 32 | Packed status word |
| pending_o | output | 3 | Per-mailbox pending flags |

## Verification
The collision of interest is a mailbox emptying, by success or by an abort taking effect, in the same cycle that software writes 1 to clear its done bit. A second case is an abort write that lands in the same cycle as a failure pulse. The bench provokes both with directed single-cycle overlaps. It also runs a long random phase that fires request, write, active and outcome inputs together. Every cycle it compares the full status word and the pending flags against a behavioural model that applies the set-wins rule.

// File: rtl/canmb_pkg.sv
package canmb_pkg;

    localparam int MB_BITS   = 8;
    localparam int STAT_W    = 32;
    localparam int B_DONE    = 0;
    localparam int B_TXOK    = 1;
    localparam int B_ALST    = 2;
    localparam int B_TERR    = 3;
    localparam int B_ABORT   = 7;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_OK   = 2'd1,
        OUT_ARB  = 2'd2,
        OUT_ERR  = 2'd3
    } outcome_e;

    typedef struct packed {
        logic pend;
        logic abort;
        logic terr;
        logic alst;
        logic txok;
        logic done;
    } mb_state_t;

    localparam mb_state_t MB_RESET = '{default: 1'b0};

    function automatic outcome_e decode_outcome(input logic ok, input logic arb, input logic err);
        if (ok)       return OUT_OK;
        else if (arb) return OUT_ARB;
        else if (err) return OUT_ERR;
        else          return OUT_NONE;
    endfunction

    function automatic logic [MB_BITS-1:0] pack_byte(input mb_state_t s);
        logic [MB_BITS-1:0] b;
        b          = '0;
        b[B_DONE]  = s.done;
        b[B_TXOK]  = s.txok;
        b[B_ALST]  = s.alst;
        b[B_TERR]  = s.terr;
        b[B_ABORT] = s.abort;
        return b;
    endfunction

endpackage

// File: rtl/canmb_slot.sv
module canmb_slot
    import canmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tx_req_i,
    input  logic      clr_done_i,
    input  logic      abort_wr_i,
    input  logic      active_i,
    input  logic      ev_ok_i,
    input  logic      ev_arb_i,
    input  logic      ev_err_i,
    output mb_state_t state_o
);

    mb_state_t q, d;
    outcome_e  outc;
    logic      start, fail, done_ok, abort_done, empty_now, clr_any, clr_eff;

    always_comb begin
        outc       = q.pend ? decode_outcome(ev_ok_i, ev_arb_i, ev_err_i) : OUT_NONE;
        start      = tx_req_i && !q.pend;
        done_ok    = (outc == OUT_OK);
        fail       = (outc == OUT_ARB) || (outc == OUT_ERR);
        abort_done = q.pend && q.abort && !done_ok && (fail || !active_i);
        empty_now  = done_ok || abort_done;
        clr_any    = start || clr_done_i;
        clr_eff    = clr_any && !empty_now;

        d = q;
        if (clr_eff) begin
            d.done = 1'b0;
            d.txok = 1'b0;
            d.alst = 1'b0;
            d.terr = 1'b0;
        end
        if (start)
            d.pend = 1'b1;
        unique case (outc)
            OUT_OK:  d.txok = 1'b1;
            OUT_ARB: begin d.txok = 1'b0; d.alst = 1'b1; end
            OUT_ERR: begin d.txok = 1'b0; d.terr = 1'b1; end
            default: ;
        endcase
        if (empty_now) begin
            d.pend  = 1'b0;
            d.abort = 1'b0;
            d.done  = 1'b1;
        end else if (q.pend && abort_wr_i) begin
            d.abort = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= MB_RESET;
        else     q <= d;
    end

    assign state_o = q;

    AST_ABORT_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        q.abort |-> q.pend);                                                   // R7
    AST_DONE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        q.done |-> !q.pend);                                                   // R4
    AST_OK_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (q.pend && ev_ok_i) |=> (!q.pend && q.done && q.txok && !q.abort));    // R4
    AST_FAIL_RETRIES: assert property (@(posedge clk) disable iff (rst)
        (q.pend && !q.abort && !ev_ok_i && (ev_arb_i || ev_err_i)) |=> (q.pend && !q.txok)); // R5
    AST_IDLE_ABORT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!q.pend && abort_wr_i) |=> !q.abort);                                 // R7
    AST_ABORT_HELD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (q.pend && q.abort && active_i && !ev_ok_i && !ev_arb_i && !ev_err_i) |=> q.pend); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (q.pend && ev_ok_i && clr_done_i) |=> q.done);                         // R9
    AST_IDLE_EVENT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!q.pend && !tx_req_i && !clr_done_i) |=> $stable(q));                 // R10

endmodule

// File: rtl/canmb_pack.sv
module canmb_pack
    import canmb_pkg::*;
#(
    parameter int NUM_MB = 3
) (
    input  mb_state_t            st_i [NUM_MB],
    output logic [STAT_W-1:0]    word_o,
    output logic [NUM_MB-1:0]    pend_o
);

    localparam int USED_W = NUM_MB * MB_BITS;

    for (genvar k = 0; k < NUM_MB; k++) begin : g_byte
        assign word_o[k*MB_BITS +: MB_BITS] = pack_byte(st_i[k]);
        assign pend_o[k]                    = st_i[k].pend;
    end

    if (USED_W < STAT_W) begin : g_pad
        assign word_o[STAT_W-1:USED_W] = '0;
    end

endmodule

// File: rtl/canmb_status.sv
module canmb_status
    import canmb_pkg::*;
#(
    parameter int NUM_MB = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_MB-1:0] tx_req_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    input  logic [NUM_MB-1:0] active_i,
    input  logic [NUM_MB-1:0] ev_ok_i,
    input  logic [NUM_MB-1:0] ev_arb_i,
    input  logic [NUM_MB-1:0] ev_err_i,
    output logic [31:0]       status_o,
    output logic [NUM_MB-1:0] pending_o
);

    mb_state_t slot_st [NUM_MB];

    for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
        canmb_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .tx_req_i   (tx_req_i[k]),
            .clr_done_i (wr_en_i && wr_data_i[k*MB_BITS + B_DONE]),
            .abort_wr_i (wr_en_i && wr_data_i[k*MB_BITS + B_ABORT]),
            .active_i   (active_i[k]),
            .ev_ok_i    (ev_ok_i[k]),
            .ev_arb_i   (ev_arb_i[k]),
            .ev_err_i   (ev_err_i[k]),
            .state_o    (slot_st[k])
        );
    end

    canmb_pack #(.NUM_MB(NUM_MB)) u_pack (
        .st_i   (slot_st),
        .word_o (status_o),
        .pend_o (pending_o)
    );

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (status_o == '0 && pending_o == '0));                  // R1

endmodule

// File: tb/canmb_status_tb_top.sv
module canmb_status_tb_top;

    localparam int N = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  tx_req, active, ev_ok, ev_arb, ev_err;
    logic          wr_en;
    logic [31:0]   wr_data;
    logic [31:0]   status;
    logic [N-1:0]  pending;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_pend [N];
    int m_abt  [N];
    int m_done [N];
    int m_ok   [N];
    int m_al   [N];
    int m_er   [N];

    always #4 clk = ~clk;

    canmb_status #(.NUM_MB(N)) dut_i (
        .clk(clk), .rst(rst), .tx_req_i(tx_req), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .active_i(active), .ev_ok_i(ev_ok), .ev_arb_i(ev_arb), .ev_err_i(ev_err),
        .status_o(status), .pending_o(pending)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected<50000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < N; m++) begin
            m_pend[m] = 0; m_abt[m] = 0; m_done[m] = 0;
            m_ok[m] = 0; m_al[m] = 0; m_er[m] = 0;
        end
    endtask

    task automatic wipe(input int m);
        m_done[m] = 0; m_ok[m] = 0; m_al[m] = 0; m_er[m] = 0;
    endtask

    task automatic retire(input int m);
        m_pend[m] = 0; m_abt[m] = 0; m_done[m] = 1;
    endtask

    task automatic model_step();
        for (int m = 0; m < N; m++) begin
            bit clr = wr_en && wr_data[8*m];
            bit abw = wr_en && wr_data[8*m+7];
            if (m_pend[m] == 0) begin
                if (tx_req[m]) begin wipe(m); m_pend[m] = 1; end
                else if (clr) wipe(m);
            end else if (ev_ok[m]) begin
                m_ok[m] = 1; retire(m);
            end else if (ev_arb[m] || ev_err[m]) begin
                if (!m_abt[m] && clr) wipe(m);
                m_ok[m] = 0;
                if (ev_arb[m]) m_al[m] = 1; else m_er[m] = 1;
                if (m_abt[m]) retire(m);
                else if (abw) m_abt[m] = 1;
            end else if (m_abt[m] && !active[m]) begin
                retire(m);
            end else begin
                if (clr) wipe(m);
                if (abw) m_abt[m] = 1;
            end
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        for (int m = 0; m < N; m++) begin
            w[8*m]   = m_done[m][0];
            w[8*m+1] = m_ok[m][0];
            w[8*m+2] = m_al[m][0];
            w[8*m+3] = m_er[m][0];
            w[8*m+7] = m_abt[m][0];
        end
        return w;
    endfunction

    function automatic string tag_for(input logic [31:0] diff);
        for (int b = 0; b < 32; b++) if (diff[b]) begin
            if (b >= 8*N)        return "R2";
            case (b % 8)
                0:       return "R6";
                1:       return "R4";
                2, 3:    return "R5";
                7:       return "R7";
                default: return "R2";
            endcase
        end
        return "R2";
    endfunction

    task automatic compare_model();
        logic [31:0] exp = model_word();
        logic [N-1:0] ep;
        for (int m = 0; m < N; m++) ep[m] = m_pend[m][0];
        chk(tag_for(status ^ exp), status, exp);
        chk("R3", {{(32-N){1'b0}}, pending}, {{(32-N){1'b0}}, ep});
    endtask

    task automatic idle_inputs();
        tx_req = '0; wr_en = 1'b0; wr_data = '0; ev_ok = '0; ev_arb = '0; ev_err = '0;
    endtask

    // one clock: inputs already set, model follows the edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        if (!rst) model_step(); else model_reset();
        @(negedge clk);
        compare_model();
        idle_inputs();
    endtask

    initial begin
        rst = 1'b1; active = '0;
        idle_inputs();
        model_reset();
        @(negedge clk);
        cyc(); cyc();
        rst = 1'b0;
        chk("R1", status, 32'h0);
        chk("R1", {29'd0, pending}, 32'h0);

        // R3 and R4: send on mailbox 0 and succeed
        tx_req[0] = 1'b1; cyc();
        chk("R3", {31'd0, pending[0]}, 32'd1);
        ev_ok[0] = 1'b1; cyc();
        chk("R4", {24'd0, status[7:0]}, 32'h03);

        // R6: write 0 leaves, write 1 clears
        wr_en = 1'b1; wr_data = 32'h0; cyc();
        chk("R6", {24'd0, status[7:0]}, 32'h03);
        wr_en = 1'b1; wr_data = 32'h1; cyc();
        chk("R6", {24'd0, status[7:0]}, 32'h00);

        // R5: mailbox 1 loses arbitration, then errors, then succeeds
        tx_req[1] = 1'b1; cyc();
        ev_arb[1] = 1'b1; cyc();
        chk("R5", {24'd0, status[15:8]}, 32'h04);
        chk("R5", {31'd0, pending[1]}, 32'd1);
        ev_err[1] = 1'b1; cyc();
        chk("R5", {24'd0, status[15:8]}, 32'h0C);
        ev_ok[1] = 1'b1; cyc();
        chk("R4", {24'd0, status[15:8]}, 32'h0F);

        // R3: new request clears outcome bits
        tx_req[1] = 1'b1; cyc();
        chk("R3", {24'd0, status[15:8]}, 32'h00);
        ev_ok[1] = 1'b1; cyc();

        // R7: abort on empty mailbox 2 ignored
        wr_en = 1'b1; wr_data = 32'h0080_0000; cyc();
        chk("R7", {24'd0, status[23:16]}, 32'h00);

        // R8: abort held while active, then taken on error
        tx_req[2] = 1'b1; active[2] = 1'b1; cyc();
        wr_en = 1'b1; wr_data = 32'h0080_0000; cyc();
        chk("R7", {24'd0, status[23:16]}, 32'h80);
        cyc(); cyc();
        chk("R8", {31'd0, pending[2]}, 32'd1);
        ev_err[2] = 1'b1; cyc();
        active[2] = 1'b0;
        chk("R8", {24'd0, status[23:16]}, 32'h09);
        chk("R8", {31'd0, pending[2]}, 32'd0);

        // R8: abort on idle mailbox 0 takes effect the cycle after it is written
        tx_req[0] = 1'b1; cyc();
        wr_en = 1'b1; wr_data = 32'h80; cyc();
        chk("R8", {24'd0, status[7:0]}, 32'h80);
        cyc();
        chk("R8", {24'd0, status[7:0]}, 32'h01);

        // R3: request on a pending mailbox ignored (outcome bits kept)
        tx_req[0] = 1'b1; active[0] = 1'b1; cyc();
        ev_arb[0] = 1'b1; cyc();
        tx_req[0] = 1'b1; cyc();
        chk("R3", {24'd0, status[7:0]}, 32'h04);

        // R9: completion and write-1 clear in the same cycle
        ev_ok[0] = 1'b1; wr_en = 1'b1; wr_data = 32'h1; cyc();
        active[0] = 1'b0;
        chk("R9", {24'd0, status[7:0]}, 32'h07);

        // R10: outcome pulses on empty mailboxes
        ev_ok = '1; cyc();
        ev_err = '1; cyc();
        chk("R10", status, model_word());
        chk("R10", {24'd0, status[7:0]}, 32'h07);

        // random phase, all inputs mixed
        for (int i = 0; i < 3000; i++) begin
            int pick;
            tx_req = N'($urandom_range(0, 7));
            active = N'($urandom_range(0, 7));
            wr_en  = ($urandom_range(0, 3) == 0);
            wr_data = $urandom;
            for (int m = 0; m < N; m++) begin
                pick = $urandom_range(0, 7);
                ev_ok[m]  = (pick == 0) || (pick == 6);
                ev_arb[m] = (pick == 1) || (pick == 6);
                ev_err[m] = (pick == 2) || (pick == 7);
            end
            if (i == 1500) rst = 1'b1;
            if (i == 1502) rst = 1'b0;
            cyc();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule